// File: doc/BRIEF.md
# Parallel NOR Bus-Operation Front End

This block sits on the device side of a parallel NOR-style memory port. A fast system clock oversamples the active-low control pins (chip select, output enable, write strobe, device reset, address strobe) and the bus clock. All pins pass through two-flop synchronizers. Each synchronized sample is then classified as one of five bus operations: device reset, standby, output-off, read or write.

The block keeps an internal address register. The register follows the address pins while the address strobe is low and holds its value while the strobe is high. The block controls the output enables of a 16-bit data bus and of a WAIT pin. Read data comes from a parameterized internal array indexed by the address register.

When a write ends, the block hands the written address and data to a downstream command interpreter as a one-cycle pulse. The write ends at the first rising edge of the write strobe or of chip select. Conflicting pin combinations are flagged on an error output.

Top module: `pnor_bus_front`

## Requirements
- R1: While the synchronized reset pin is low, `op_state` is 0 (reset), `dq_oe` and `wait_oe` are low, and no write is captured. Reset dominates every other pin.
- R2: With reset high and `ce_n` high, `op_state` is 1 (standby) and both output enables are low, whatever the level of `oe_n`.
- R3: With reset high, `ce_n` low, `oe_n` low and `we_n` high, `op_state` is 3 (read) and `dq_oe` and `wait_oe` are high. In steady state `dq_out` equals the array word at the address register, where word(a) = (a × 0x0101) XOR 0x3C5A, truncated to 16 bits.
- R4: With reset high, `ce_n` low, `we_n` low and `oe_n` high, `op_state` is 4 (write) and both output enables are low.
- R5: With reset high, `ce_n` low and `oe_n`/`we_n` both high, `op_state` is 2 (output-off) and both output enables are low.
- R6: With reset high and `ce_n`, `oe_n` and `we_n` all low, `bus_err` is high and the operation is treated as output-off (`op_state` 2, enables low). `bus_err` is low for every other combination.
- R7: The address register loads the address pins while `adv_n` is low. While `adv_n` is high it keeps its value.
- R8: Leaving a write with reset still high, and with `we_n` or `ce_n` rising, produces exactly one `wr_valid` pulse of one cycle. The pulse carries the data that was on the bus and the address register value from the write.
- R9: When `we_n` and `ce_n` rise in the same sample, a single capture results, not two.
- R10: Without bus-clock edges in the last `CLK_IDLE` system cycles, WAIT is driven low throughout a read. With a running bus clock, WAIT is driven high for exactly the first read cycle and low after that. WAIT is never high while its enable is low.
- R11: `dq_oe` is high exactly in the cycles where `op_state` is 3, so the data bus is released in the same cycle the decoded operation leaves read.
- R12: The pin inputs take effect through two synchronizer stages. The decoded state reflects a pin change within three system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | System reset, active low |
| ce_n | input | 1 | Chip select pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write strobe pin, active low |
| dev_rst_n | input | 1 | Device reset pin, active low |
| adv_n | input | 1 | Address strobe pin, active low |
| bus_clk | input | 1 | Bus clock pin, oversampled |
| addr_in | input | AW | Address pins |
| dq_in | input | 16 | Data bus, input side |
| dq_out | output | 16 | Data bus, output side |
| dq_oe | output | 1 | Data bus drive enable |
| wait_out | output | 1 | WAIT level, active high |
| wait_oe | output | 1 | WAIT drive enable |
| op_state | output | 3 | Decoded operation: 0 reset, 1 standby, 2 output-off, 3 read, 4 write |
| bus_err | output | 1 | Conflicting control combination |
| wr_valid | output | 1 | One-cycle write hand-off pulse |
| wr_addr | output | AW | Captured write address |
| wr_data | output | 16 | Captured write data |

## Verification
Random pin combinations are drawn with chip select and reset biased toward active. This covers all five operations and also the transitions out of a write. The transitions show whether a capture fires on the write-strobe edge, on the chip-select edge, on both together, or wrongly on a transition into reset. Random strobe levels and addresses between steps tell a held address register from a transparent one, because read data is then compared with the model's address. Directed sequences toggle the bus clock and then stop it, which tells a synchronous read, with one WAIT-high cycle, from an asynchronous read with WAIT held low.

// File: rtl/pnor_pkg.sv
package pnor_pkg;

  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_STBY  = 3'd1,
    OP_ODIS  = 3'd2,
    OP_READ  = 3'd3,
    OP_WRITE = 3'd4
  } op_e;

  localparam int DQ_W = 16;

  // operation decode from active-low pin levels; reset pin dominates
  function automatic op_e classify(input logic ce_n, input logic oe_n,
                                   input logic we_n, input logic drst_n);
    if (!drst_n)            return OP_RESET;
    if (ce_n)               return OP_STBY;
    if (!oe_n && !we_n)     return OP_ODIS;
    if (!oe_n)              return OP_READ;
    if (!we_n)              return OP_WRITE;
    return OP_ODIS;
  endfunction

  function automatic logic conflict(input logic ce_n, input logic oe_n,
                                    input logic we_n, input logic drst_n);
    return drst_n && !ce_n && !oe_n && !we_n;
  endfunction

  // content of the internal read array
  function automatic logic [DQ_W-1:0] array_word(input int unsigned a);
    logic [DQ_W-1:0] base;
    base = DQ_W'(a);
    return DQ_W'(base * 16'h0101) ^ 16'h3C5A;
  endfunction

endpackage

// File: rtl/pnor_sync.sv
module pnor_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= RSTV;
      q   <= RSTV;
    end else begin
      st1 <= d;
      q   <= st1;
    end
  end
endmodule

// File: rtl/pnor_classify.sv
module pnor_classify
  import pnor_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic drst_n,
  output op_e  op_q,
  output logic err_q
);
  op_e  op_c;
  logic err_c;

  always_comb begin
    op_c  = classify(ce_n, oe_n, we_n, drst_n);
    err_c = conflict(ce_n, oe_n, we_n, drst_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_RESET;
      err_q <= 1'b0;
    end else begin
      op_q  <= op_c;
      err_q <= err_c;
    end
  end

  // R1
  reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drst_n |=> (op_q == OP_RESET));
  // R2
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drst_n && ce_n) |=> (op_q == OP_STBY));
  // R6
  conflict_odis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (op_q == OP_ODIS));
endmodule

// File: rtl/pnor_wrcap.sv
module pnor_wrcap #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          drst_n,
  input  logic          prv_ce_n,
  input  logic          prv_oe_n,
  input  logic          prv_we_n,
  input  logic          prv_drst_n,
  input  logic [15:0]   dq_prev,
  input  logic [AW-1:0] lat_addr,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data
);
  logic prev_write, rise_we, rise_ce, cap_evt;

  assign prev_write = prv_drst_n && !prv_ce_n && !prv_we_n && prv_oe_n;
  assign rise_we    = !prv_we_n && we_n;
  assign rise_ce    = !prv_ce_n && ce_n;
  // either edge, or both in one sample, yields one event
  assign cap_evt    = prev_write && drst_n && (rise_we || rise_ce);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= cap_evt;
      if (cap_evt) begin
        wr_addr <= lat_addr;
        wr_data <= dq_prev;
      end
    end
  end

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R1
  no_cap_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drst_n |=> !wr_valid);
  // R9
  both_edges_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_we && rise_ce && cap_evt) |=> (wr_valid ##1 !wr_valid));
endmodule

// File: rtl/pnor_rdpath.sv
module pnor_rdpath
  import pnor_pkg::*;
#(
  parameter int AW       = 8,
  parameter int CLK_IDLE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op_q,
  input  logic [AW-1:0] lat_addr,
  input  logic          bclk_edge,
  output logic [15:0]   dq_out,
  output logic          dq_oe,
  output logic          wait_out,
  output logic          wait_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(CLK_IDLE + 1);
  localparam logic [CW-1:0] IDLE_MAX = CW'(CLK_IDLE);

  logic [15:0] mem [DEPTH];
  logic [15:0] rd_data;
  op_e         op_d;
  logic [CW-1:0] idle_cnt;
  logic        bus_run, rd_first;

  for (genvar g = 0; g < DEPTH; g++) begin : g_arr
    assign mem[g] = array_word(g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      op_d     <= OP_RESET;
      idle_cnt <= IDLE_MAX;
    end else begin
      rd_data <= mem[lat_addr];
      op_d    <= op_q;
      if (bclk_edge)               idle_cnt <= '0;
      else if (idle_cnt != IDLE_MAX) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign bus_run  = (idle_cnt != IDLE_MAX);
  assign rd_first = (op_q == OP_READ) && (op_d != OP_READ);
  assign dq_oe    = (op_q == OP_READ);
  assign wait_oe  = (op_q == OP_READ);
  assign wait_out = wait_oe && bus_run && rd_first;
  assign dq_out   = rd_data;

  // R10
  wait_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_out |-> wait_oe);
  // R10
  wait_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_out |=> !wait_out);
  // R11
  release_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_d == OP_READ && op_q != OP_READ) |-> !dq_oe);
endmodule

// File: rtl/pnor_bus_front.sv
module pnor_bus_front
  import pnor_pkg::*;
#(
  parameter int AW       = 8,
  parameter int CLK_IDLE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          dev_rst_n,
  input  logic          adv_n,
  input  logic          bus_clk,
  input  logic [AW-1:0] addr_in,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic          dq_oe,
  output logic          wait_out,
  output logic          wait_oe,
  output logic [2:0]    op_state,
  output logic          bus_err,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data
);
  localparam int PW = 6;
  // {ce_n, oe_n, we_n, dev_rst_n, adv_n, bus_clk}
  localparam logic [PW-1:0] PIN_IDLE = 6'b111010;

  logic [PW-1:0] pin_s, pin_d;
  logic [AW-1:0] addr_s, lat_addr;
  logic [15:0]   dq_s, dq_prev;
  logic          bclk_edge;
  op_e           op_q;

  pnor_sync #(.W(PW), .RSTV(PIN_IDLE)) u_psync (
    .clk(clk), .rst_n(rst_n),
    .d({ce_n, oe_n, we_n, dev_rst_n, adv_n, bus_clk}), .q(pin_s));
  pnor_sync #(.W(AW)) u_async (
    .clk(clk), .rst_n(rst_n), .d(addr_in), .q(addr_s));
  pnor_sync #(.W(16)) u_dsync (
    .clk(clk), .rst_n(rst_n), .d(dq_in), .q(dq_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d    <= PIN_IDLE;
      dq_prev  <= '0;
      lat_addr <= '0;
    end else begin
      pin_d   <= pin_s;
      dq_prev <= dq_s;
      if (!pin_s[1]) lat_addr <= addr_s;
    end
  end

  assign bclk_edge = pin_s[0] ^ pin_d[0];

  pnor_classify u_cls (
    .clk(clk), .rst_n(rst_n),
    .ce_n(pin_s[5]), .oe_n(pin_s[4]), .we_n(pin_s[3]), .drst_n(pin_s[2]),
    .op_q(op_q), .err_q(bus_err));

  pnor_wrcap #(.AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .ce_n(pin_s[5]), .we_n(pin_s[3]), .drst_n(pin_s[2]),
    .prv_ce_n(pin_d[5]), .prv_oe_n(pin_d[4]), .prv_we_n(pin_d[3]),
    .prv_drst_n(pin_d[2]),
    .dq_prev(dq_prev), .lat_addr(lat_addr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data));

  pnor_rdpath #(.AW(AW), .CLK_IDLE(CLK_IDLE)) u_rd (
    .clk(clk), .rst_n(rst_n), .op_q(op_q), .lat_addr(lat_addr),
    .bclk_edge(bclk_edge), .dq_out(dq_out), .dq_oe(dq_oe),
    .wait_out(wait_out), .wait_oe(wait_oe));

  assign op_state = op_q;

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_s[1] |=> $stable(lat_addr));
  // R5
  outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_READ) |-> (!wait_oe && !wait_out));
endmodule

// File: tb/sim_pnor_bus_front.sv
module sim_pnor_bus_front;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dev_rst_n = 1'b0, adv_n = 1'b1;
  logic bus_clk = 1'b0, bclk_en = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, wr_data;
  logic dq_oe, wait_out, wait_oe, bus_err, wr_valid;
  logic [2:0] op_state;
  logic [AW-1:0] wr_addr;

  int checks = 0, errors = 0;
  int pulses = 0, wait_hi = 0, oe_mism = 0;
  logic [15:0] last_wd;
  logic [AW-1:0] last_wa;
  logic done = 1'b0;

  always #4 clk = ~clk;

  pnor_bus_front #(.AW(AW), .CLK_IDLE(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dev_rst_n(dev_rst_n), .adv_n(adv_n), .bus_clk(bus_clk),
    .addr_in(addr_in), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .wait_out(wait_out), .wait_oe(wait_oe), .op_state(op_state),
    .bus_err(bus_err), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data));

  always @(negedge clk) begin
    if (bclk_en) bus_clk <= ~bus_clk;
    if (rst_n) begin
      if (wr_valid) begin pulses++; last_wd = wr_data; last_wa = wr_addr; end
      if (wait_out) wait_hi++;
      if (dq_oe != (op_state == 3'd3)) oe_mism++;
      if (wait_out && !wait_oe) oe_mism++;
    end
  end

  function automatic int exp_op(logic r, logic c, logic o, logic w);
    if (!r) return 0;
    if (c) return 1;
    if (!o && !w) return 2;
    if (!o) return 3;
    if (!w) return 4;
    return 2;
  endfunction

  function automatic logic [15:0] exp_word(logic [AW-1:0] a);
    logic [15:0] x;
    x = {8'h00, a};
    return {x[7:0], x[7:0]} ^ 16'h3C5A;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic c, input logic o, input logic w,
                       input logic a, input logic [AW-1:0] ad, input logic [15:0] d);
    @(negedge clk);
    dev_rst_n = r; ce_n = c; oe_n = o; we_n = w; adv_n = a; addr_in = ad; dq_in = d;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic pr, pc, po, pw;
    logic [AW-1:0] maddr;
    logic [15:0] pd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(op_state == 0 && !dq_oe && !wait_oe && !wr_valid, "R1 reset", op_state, 0);

    // R12 latency: change to standby, sample after 2 and 3 clocks
    drive(1, 1, 1, 1, 1, 0, 0);
    repeat (2) @(negedge clk);
    chk(op_state == 0, "R12 not before sync", op_state, 0);
    @(negedge clk);
    chk(op_state == 1, "R12 after three clocks", op_state, 1);

    pr = 1; pc = 1; po = 1; pw = 1; pd = 0; maddr = 0;
    // directed: write ended by both edges together (R9), then by CE (R8)
    drive(1, 0, 1, 0, 0, 8'h5C, 16'hBEEF);
    repeat (6) @(negedge clk);
    pulses = 0;
    drive(1, 1, 1, 1, 1, 8'h00, 16'h0000);
    repeat (6) @(negedge clk);
    chk(pulses == 1, "R9 simultaneous edges one capture", pulses, 1);
    chk(last_wd == 16'hBEEF && last_wa == 8'h5C, "R8 capture data", last_wd, 16'hBEEF);
    drive(1, 0, 1, 0, 1, 8'h00, 16'h1234);
    repeat (6) @(negedge clk);
    chk(op_state == 4 && !dq_oe, "R4 write state", op_state, 4);
    pulses = 0;
    drive(1, 1, 1, 0, 1, 8'h00, 16'h0);
    repeat (6) @(negedge clk);
    chk(pulses == 1 && last_wd == 16'h1234 && last_wa == 8'h5C, "R8 CE edge capture",
        last_wd, 16'h1234);
    maddr = 8'h5C;

    // directed R2: standby with oe low
    drive(1, 1, 0, 1, 1, 0, 0);
    repeat (6) @(negedge clk);
    chk(op_state == 1 && !dq_oe && !wait_oe, "R2 standby ignores oe", op_state, 1);

    // directed R10 sync read: bus clock running
    bclk_en = 1'b1;
    repeat (4) @(negedge clk);
    wait_hi = 0;
    drive(1, 0, 0, 1, 1, 0, 0);
    repeat (8) @(negedge clk);
    chk(wait_hi == 1 && wait_oe, "R10 sync read wait one cycle", wait_hi, 1);
    chk(dq_out == exp_word(maddr), "R3 read data", dq_out, exp_word(maddr));
    bclk_en = 1'b0;
    drive(1, 1, 1, 1, 1, 0, 0);
    repeat (20) @(negedge clk);
    wait_hi = 0;
    drive(1, 0, 0, 1, 1, 0, 0);
    repeat (8) @(negedge clk);
    chk(wait_hi == 0 && wait_oe, "R10 async read wait low", wait_hi, 0);
    pr = 1; pc = 0; po = 0; pw = 1; pd = 0;

    for (int i = 0; i < 400; i++) begin
      logic r, c, o, w, a;
      logic [AW-1:0] ad;
      logic [15:0] d;
      int eo;
      logic expcap;
      r = ($urandom_range(99) < 88);
      c = ($urandom_range(99) < 25);
      o = $urandom_range(1);
      w = $urandom_range(1);
      a = $urandom_range(1);
      ad = AW'($urandom);
      d = 16'($urandom);
      expcap = pr && !pc && !pw && po && r && (w || c);
      pulses = 0; wait_hi = 0;
      drive(r, c, o, w, a, ad, d);
      repeat (6) @(negedge clk);
      eo = exp_op(r, c, o, w);
      chk(op_state == eo, "R1 R2 R3 R4 R5 decode", op_state, eo);
      chk(bus_err == (r && !c && !o && !w), "R6 conflict flag", bus_err, r && !c && !o && !w);
      chk(dq_oe == (eo == 3) && wait_oe == (eo == 3), "R5 enables", dq_oe, eo == 3);
      chk(pulses == int'(expcap), "R8 capture count", pulses, expcap);
      if (expcap)
        chk(last_wd == pd && last_wa == maddr, "R8 capture fields", last_wd, pd);
      if (!a) maddr = ad;
      if (eo == 3)
        chk(dq_out == exp_word(maddr), "R7 R3 latched read data", dq_out, exp_word(maddr));
      chk(wait_hi == 0, "R10 async wait", wait_hi, 0);
      pr = r; pc = c; po = o; pw = w; pd = d;
    end
    chk(oe_mism == 0, "R11 bus enable tracks read", oe_mism, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule